// File: doc/BRIEF.md
# Timer/counter with match and capture channels

This block is a general-purpose 32-bit timer. In timer mode a free-running prescale counter divides the clock. The main counter advances once each time the prescale counter wraps. In counter mode the main counter advances instead on chosen edges of an external count pin. The prescaler is bypassed in that mode. Four compare registers watch the counter. On an equality each one can flag an interrupt, force the counter back to zero, or halt counting. Each compare register also drives an output pin with a programmable action.

Four capture channels watch their own input pins. On a selected edge a channel copies the counter into its capture register. It can also flag an interrupt. Software talks to the block through a plain single-cycle register port: writes take effect at the clock edge on which `reg_we` is high, and reads are combinational from `reg_addr`. Every register port and pin is a control or status signal. There is no streaming data path, so the block carries no valid/ready handshake and never applies back-pressure.

Top module: `match_capture_timer`

Register word addresses (defaults):

| Address | Meaning |
|---|---|
| 0 | control: bit0 run, bit1 hold-clear, bit2 mode (0 timer, 1 counter), bits4:3 count-edge select |
| 1 | interrupt flags: bits 3:0 compare 0..3, bits 7:4 capture 0..3 |
| 2 | main counter |
| 3 | prescale limit |
| 4 | prescale counter (read only) |
| 5 | compare options, 3 bits per channel i: bit 3i interrupt, 3i+1 zero counter, 3i+2 halt |
| 6 | capture options, 3 bits per channel j: bit 3j rising, 3j+1 falling, 3j+2 interrupt |
| 7 | pin actions, 2 bits per compare channel at bits 2i+1:2i |
| 8..11 | compare values 0..3 |
| 12..15 | capture values 0..3 (read only) |
| 16 | compare pin levels, bit i = pin i (read/write) |

## Requirements
- R1: After reset every register reads zero, all compare pins are low and `irq` is low.
- R2: In timer mode with run set, the prescale counter increments on each clock and wraps to zero on the clock where it equals the prescale limit, and the main counter increments on that same clock; after E enabled clocks from zero the main counter reads E/(P+1) and the prescale counter reads E mod (P+1).
- R3: In counter mode the main counter increments once per edge of `count_in`, after a two-flop synchroniser, selected by control bits 4:3 (00 none, 01 rising, 10 falling, 11 both), and the prescale limit has no effect.
- R4: A compare match happens on a counting step while the main counter equals a compare value. With the zero option set, the counter becomes 0 instead of incrementing.
- R5: A match with the halt option set clears the run bit and leaves the main counter at the compare value.
- R6: On a match, compare pin i follows its 2-bit action: 00 unchanged, 01 low, 10 high, 11 toggle; writing address 16 sets the pin levels directly.
- R7: A capture channel loads the main counter into its capture register on a synchronised rising edge if its rising bit is set, and on a falling edge if its falling bit is set. With neither bit set, the register keeps its value.
- R8: A match or capture event with its interrupt option set raises its flag bit. Writing 1 to a flag bit clears it, writing 0 leaves it unchanged, and `irq` is high exactly when any flag is set.
- R9: While the hold-clear control bit is set, both counters stay at zero, even when software writes the main counter.
- R10: Writing the main counter loads it and clears the prescale counter on the same edge, even while counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| count_in | input | 1 | External count pin |
| cap_in | input | 4 | Capture pins |
| match_out | output | 4 | Compare output pins |
| irq | output | 1 | OR of all interrupt flags |

## Verification
A register write is visible to a read at the negative edge that follows its write edge. A match changes the pins, the flags, the run bit and the counter on the edge where the matching counting step occurs. A pin change on `count_in` or `cap_in` takes three clock edges to reach the counter or the capture register: two synchroniser stages and one edge to act. The bench waits five edges after each such change before it reads. It steps the counter only while run is set, over an exactly counted number of edges, so every expected value is plain arithmetic on that count: a quotient and remainder for the prescaler, and a modulus for the auto-zeroing match.

// File: rtl/mct_pkg.sv
package mct_pkg;
  // register word offsets
  localparam int A_CTRL    = 0;
  localparam int A_FLAGS   = 1;
  localparam int A_COUNT   = 2;
  localparam int A_PSCALE  = 3;
  localparam int A_PCOUNT  = 4;
  localparam int A_MCFG    = 5;
  localparam int A_CCFG    = 6;
  localparam int A_ACT     = 7;
  localparam int MVAL_BASE = 8;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } match_act_e;

  function automatic logic next_level(match_act_e a, logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/mct_sync_edge.sv
module mct_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/mct_count_core.sv
module mct_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold_clr,
  input  logic             mode_ext,
  input  logic             ext_tick,
  input  logic [CNT_W-1:0] pscale,
  input  logic             wr_count,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             any_reset,
  input  logic             any_stop,
  output logic             tick,
  output logic [CNT_W-1:0] tc,
  output logic [CNT_W-1:0] pc
);
  logic pc_wrap;

  assign pc_wrap = (pc >= pscale);
  assign tick    = run && !hold_clr && (mode_ext ? ext_tick : pc_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (hold_clr || wr_count) begin
      pc <= '0;
    end else if (run && !mode_ext) begin
      pc <= pc_wrap ? '0 : pc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc <= '0;
    end else if (hold_clr) begin
      tc <= '0;
    end else if (wr_count) begin
      tc <= wr_val;
    end else if (tick) begin
      if (any_reset)     tc <= '0;
      else if (!any_stop) tc <= tc + 1'b1;
    end
  end
endmodule

// File: rtl/mct_match_bank.sv
module mct_match_bank
  import mct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [CNT_W-1:0]      tc,
  input  logic [N-1:0][CNT_W-1:0] mval,
  input  logic [N-1:0]          en_reset,
  input  logic [N-1:0]          en_stop,
  input  logic [2*N-1:0]        act,
  input  logic                  wr_lvl,
  input  logic [N-1:0]          wr_lvl_val,
  output logic [N-1:0]          hit,
  output logic                  any_reset,
  output logic                  any_stop,
  output logic [N-1:0]          lvl
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    assign hit[i] = tick && (tc == mval[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl[i] <= 1'b0;
      end else if (wr_lvl) begin
        lvl[i] <= wr_lvl_val[i];
      end else if (hit[i]) begin
        lvl[i] <= next_level(match_act_e'(act[2*i +: 2]), lvl[i]);
      end
    end
  end

  assign any_reset = |(hit & en_reset);
  assign any_stop  = |(hit & en_stop);
endmodule

// File: rtl/mct_capture_bank.sv
module mct_capture_bank #(
  parameter int CNT_W = 32,
  parameter int N     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            rise,
  input  logic [N-1:0]            fall,
  input  logic [N-1:0]            en_rise,
  input  logic [N-1:0]            en_fall,
  input  logic [CNT_W-1:0]        tc,
  output logic [N-1:0]            evt,
  output logic [N-1:0][CNT_W-1:0] cap
);
  for (genvar j = 0; j < N; j++) begin : g_cap
    assign evt[j] = (rise[j] && en_rise[j]) || (fall[j] && en_fall[j]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap[j] <= '0;
      else if (evt[j]) cap[j] <= tc;
    end
  end
endmodule

// File: rtl/match_capture_timer.sv
module match_capture_timer
  import mct_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  input  logic               count_in,
  input  logic [N_CAP-1:0]   cap_in,
  output logic [N_MATCH-1:0] match_out,
  output logic               irq
);
  localparam int NF       = N_MATCH + N_CAP;
  localparam int CAP_BASE = MVAL_BASE + N_MATCH;
  localparam int LVL_ADDR = CAP_BASE + N_CAP;

  // control state
  logic                          run_q, clr_q, mode_q;
  logic [1:0]                    edge_q;
  logic [CNT_W-1:0]              pscale_q;
  logic [3*N_MATCH-1:0]          mcfg_q;
  logic [3*N_CAP-1:0]            ccfg_q;
  logic [2*N_MATCH-1:0]          act_q;
  logic [N_MATCH-1:0][CNT_W-1:0] mval_q;
  logic [NF-1:0]                 flags_q;

  // decoded writes
  logic we_ctrl, we_flags, wr_count, wr_lvl;
  assign we_ctrl  = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign we_flags = reg_we && (reg_addr == ADDR_W'(A_FLAGS));
  assign wr_count = reg_we && (reg_addr == ADDR_W'(A_COUNT));
  assign wr_lvl   = reg_we && (reg_addr == ADDR_W'(LVL_ADDR));

  // field unpacking
  logic [N_MATCH-1:0] m_irq, m_rst, m_stop;
  logic [N_CAP-1:0]   c_rise, c_fall, c_irq;
  for (genvar i = 0; i < N_MATCH; i++) begin : g_mf
    assign m_irq[i]  = mcfg_q[3*i];
    assign m_rst[i]  = mcfg_q[3*i+1];
    assign m_stop[i] = mcfg_q[3*i+2];
  end
  for (genvar j = 0; j < N_CAP; j++) begin : g_cf
    assign c_rise[j] = ccfg_q[3*j];
    assign c_fall[j] = ccfg_q[3*j+1];
    assign c_irq[j]  = ccfg_q[3*j+2];
  end

  // input conditioning
  logic             cnt_rise, cnt_fall, ext_tick;
  logic [N_CAP-1:0] cap_rise, cap_fall;

  mct_sync_edge #(.W(1)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(count_in),
    .rise(cnt_rise), .fall(cnt_fall)
  );

  mct_sync_edge #(.W(N_CAP)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in),
    .rise(cap_rise), .fall(cap_fall)
  );

  assign ext_tick = (edge_q[0] && cnt_rise) || (edge_q[1] && cnt_fall);

  // counting
  logic             tick, any_reset, any_stop;
  logic [CNT_W-1:0] tc, pc;
  logic [N_MATCH-1:0] hit;

  mct_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_q), .hold_clr(clr_q),
    .mode_ext(mode_q), .ext_tick(ext_tick), .pscale(pscale_q),
    .wr_count(wr_count), .wr_val(reg_wdata),
    .any_reset(any_reset), .any_stop(any_stop),
    .tick(tick), .tc(tc), .pc(pc)
  );

  mct_match_bank #(.CNT_W(CNT_W), .N(N_MATCH)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tc(tc), .mval(mval_q),
    .en_reset(m_rst), .en_stop(m_stop), .act(act_q),
    .wr_lvl(wr_lvl), .wr_lvl_val(reg_wdata[N_MATCH-1:0]),
    .hit(hit), .any_reset(any_reset), .any_stop(any_stop),
    .lvl(match_out)
  );

  logic [N_CAP-1:0]            cap_evt;
  logic [N_CAP-1:0][CNT_W-1:0] cap_val;

  mct_capture_bank #(.CNT_W(CNT_W), .N(N_CAP)) u_cap (
    .clk(clk), .rst_n(rst_n), .rise(cap_rise), .fall(cap_fall),
    .en_rise(c_rise), .en_fall(c_fall), .tc(tc),
    .evt(cap_evt), .cap(cap_val)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      clr_q  <= 1'b0;
      mode_q <= 1'b0;
      edge_q <= 2'b00;
    end else if (we_ctrl) begin
      run_q  <= reg_wdata[0];
      clr_q  <= reg_wdata[1];
      mode_q <= reg_wdata[2];
      edge_q <= reg_wdata[4:3];
    end else if (any_stop) begin
      run_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pscale_q <= '0;
      mcfg_q   <= '0;
      ccfg_q   <= '0;
      act_q    <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(A_PSCALE)) pscale_q <= reg_wdata;
      if (reg_addr == ADDR_W'(A_MCFG))   mcfg_q   <= reg_wdata[3*N_MATCH-1:0];
      if (reg_addr == ADDR_W'(A_CCFG))   ccfg_q   <= reg_wdata[3*N_CAP-1:0];
      if (reg_addr == ADDR_W'(A_ACT))    act_q    <= reg_wdata[2*N_MATCH-1:0];
    end
  end

  for (genvar i = 0; i < N_MATCH; i++) begin : g_mval
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mval_q[i] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(MVAL_BASE + i))
        mval_q[i] <= reg_wdata;
    end
  end

  // interrupt flags: new events win over a same-cycle clear
  logic [NF-1:0] flag_clr, flag_set;
  assign flag_clr = we_flags ? reg_wdata[NF-1:0] : '0;
  assign flag_set = {cap_evt & c_irq, hit & m_irq};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq = |flags_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL))
      reg_rdata = CNT_W'({edge_q, mode_q, clr_q, run_q});
    if (reg_addr == ADDR_W'(A_FLAGS))  reg_rdata = CNT_W'(flags_q);
    if (reg_addr == ADDR_W'(A_COUNT))  reg_rdata = tc;
    if (reg_addr == ADDR_W'(A_PSCALE)) reg_rdata = pscale_q;
    if (reg_addr == ADDR_W'(A_PCOUNT)) reg_rdata = pc;
    if (reg_addr == ADDR_W'(A_MCFG))   reg_rdata = CNT_W'(mcfg_q);
    if (reg_addr == ADDR_W'(A_CCFG))   reg_rdata = CNT_W'(ccfg_q);
    if (reg_addr == ADDR_W'(A_ACT))    reg_rdata = CNT_W'(act_q);
    if (reg_addr == ADDR_W'(LVL_ADDR)) reg_rdata = CNT_W'(match_out);
    for (int i = 0; i < N_MATCH; i++)
      if (reg_addr == ADDR_W'(MVAL_BASE + i)) reg_rdata = mval_q[i];
    for (int j = 0; j < N_CAP; j++)
      if (reg_addr == ADDR_W'(CAP_BASE + j)) reg_rdata = cap_val[j];
  end
endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick,
  input logic                          any_reset,
  input logic                          any_stop,
  input logic                          clr_q,
  input logic                          wr_count,
  input logic                          we_ctrl,
  input logic                          we_flags,
  input logic                          wr_lvl,
  input logic                          run_q,
  input logic [CNT_W-1:0]              tc,
  input logic [CNT_W-1:0]              pc,
  input logic [CNT_W-1:0]              reg_wdata,
  input logic [N_MATCH-1:0]            hit,
  input logic [N_CAP-1:0]              cap_evt,
  input logic [N_CAP-1:0][CNT_W-1:0]   cap_val,
  input logic [N_MATCH-1:0]            match_out,
  input logic                          irq
);
  localparam int NF = N_MATCH + N_CAP;

  // R2: without a counting step or a write the counter holds
  a_r2_tc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_count && !clr_q) |=> (tc == $past(tc)));

  // R4: auto-zero match
  a_r4_zero_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && any_reset && !clr_q && !wr_count) |=> (tc == '0));

  // R5: halting match clears run
  a_r5_halt_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stop && !we_ctrl) |=> !run_q);

  // R6: pins only move on a match or a direct write
  a_r6_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|hit) && !wr_lvl) |=> $stable(match_out));

  // R7: capture registers only move on an event
  a_r7_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|cap_evt) |=> $stable(cap_val));

  // R8: clearing every flag with no new event drops irq
  a_r8_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (we_flags && (&reg_wdata[NF-1:0]) && !(|hit) && !(|cap_evt)) |=> !irq);

  // R9: hold-clear keeps both counters at zero
  a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (tc == '0 && pc == '0));
endmodule

bind match_capture_timer mct_checker #(
  .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP)
) u_mct_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick), .any_reset(any_reset),
  .any_stop(any_stop), .clr_q(clr_q), .wr_count(wr_count),
  .we_ctrl(we_ctrl), .we_flags(we_flags), .wr_lvl(wr_lvl),
  .run_q(run_q), .tc(tc), .pc(pc), .reg_wdata(reg_wdata),
  .hit(hit), .cap_evt(cap_evt), .cap_val(cap_val),
  .match_out(match_out), .irq(irq)
);

// File: tb/test_match_capture_timer.sv
module test_match_capture_timer;
  localparam int AW = 5;
  localparam logic [AW-1:0] CTRL = 0, FLAGS = 1, COUNT = 2, PSC = 3, PCNT = 4,
                            MCFG = 5, CCFG = 6, ACT = 7, MV0 = 8, CAP0 = 12, LVL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          count_in = 1'b0;
  logic [3:0]    cap_in = '0;
  logic [3:0]    match_out;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  match_capture_timer i_match_capture_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_in(count_in),
    .cap_in(cap_in), .match_out(match_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp_cap [4];
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(CTRL, v);  chk("R1 ctrl", v, 0);
    rd(COUNT, v); chk("R1 count", v, 0);
    rd(PCNT, v);  chk("R1 pcount", v, 0);
    rd(FLAGS, v); chk("R1 flags", v, 0);
    rd(CAP0, v);  chk("R1 capture0", v, 0);
    chk("R1 pins", 32'(match_out), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 prescaler sweep: E = g+1 enabled edges
    for (int p = 0; p < 5; p++) begin
      for (int g = 0; g < 12; g++) begin
        wr(PSC, 32'(p));
        wr(COUNT, 0);
        wr(CTRL, 1);
        idle(g);
        wr(CTRL, 0);
        rd(COUNT, v); chk("R2 counter", v, 32'((g + 1) / (p + 1)));
        rd(PCNT, v);  chk("R2 prescale count", v, 32'((g + 1) % (p + 1)));
      end
    end

    // R10 write while counting
    wr(PSC, 3);
    wr(COUNT, 0);
    wr(CTRL, 1);
    idle(2);
    wr(COUNT, 1000);
    rd(COUNT, v); chk("R10 loaded", v, 1000);
    rd(PCNT, v);  chk("R10 prescale cleared", v, 0);
    wr(CTRL, 0);

    // R9 hold-clear
    wr(CTRL, 3);
    idle(5);
    rd(COUNT, v); chk("R9 counter held", v, 0);
    rd(PCNT, v);  chk("R9 prescale held", v, 0);
    wr(COUNT, 55);
    rd(COUNT, v); chk("R9 write blocked", v, 0);
    wr(CTRL, 0);

    // R4 auto-zero at 5: period 6
    do_reset();
    wr(MV0, 5);
    wr(MCFG, 32'b010);
    for (int g = 0; g < 15; g++) begin
      wr(COUNT, 0);
      wr(CTRL, 1);
      idle(g);
      wr(CTRL, 0);
      rd(COUNT, v); chk("R4 wrap", v, 32'((g + 1) % 6));
    end

    // R5 / R8 halt on channel 1 at 7 with interrupt
    do_reset();
    wr(MV0 + 1, 7);
    wr(MCFG, 32'h28);
    wr(CTRL, 1);
    idle(20);
    rd(CTRL, v);  chk("R5 run cleared", v & 1, 0);
    rd(COUNT, v); chk("R5 counter held", v, 7);
    rd(FLAGS, v); chk("R8 flag set", v, 32'h2);
    chk("R8 irq high", 32'(irq), 1);
    wr(FLAGS, 0);
    rd(FLAGS, v); chk("R8 zero write ignored", v, 32'h2);
    wr(FLAGS, 32'h2);
    rd(FLAGS, v); chk("R8 flag cleared", v, 0);
    chk("R8 irq low", 32'(irq), 0);

    // R6 pin action sweep: all compare values 3, one pass through 3
    do_reset();
    for (int i = 0; i < 4; i++) wr(MV0 + AW'(i), 3);
    for (int a = 0; a < 4; a++) begin
      for (int init = 0; init < 2; init++) begin
        logic [31:0] pack;
        pack = 0;
        for (int i = 0; i < 4; i++) pack[2*i +: 2] = 2'((a + i) % 4);
        wr(COUNT, 0);
        wr(ACT, pack);
        wr(LVL, init ? 32'hF : 32'h0);
        wr(CTRL, 1);
        idle(4);
        wr(CTRL, 0);
        for (int i = 0; i < 4; i++) begin
          int act;
          logic e;
          act = (a + i) % 4;
          e = (act == 0) ? 1'(init) : (act == 1) ? 1'b0 : (act == 2) ? 1'b1 : ~1'(init);
          chk("R6 pin action", 32'(match_out[i]), 32'(e));
        end
      end
    end

    // R3 counter mode edge select
    do_reset();
    for (int es = 0; es < 4; es++) begin
      wr(COUNT, 0);
      wr(CTRL, 32'(1 | (1 << 2) | (es << 3)));
      for (int k = 0; k < 3; k++) begin
        count_in = 1'b1; idle(4);
        count_in = 1'b0; idle(4);
      end
      idle(4);
      rd(COUNT, v);
      chk("R3 edge count", v, 32'((es == 0) ? 0 : (es == 3) ? 6 : 3));
    end
    wr(CTRL, 0);

    // R7 / R8 capture sweep
    do_reset();
    for (int j = 0; j < 4; j++) exp_cap[j] = 0;
    for (int j = 0; j < 4; j++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] v1;
        wr(CCFG, 32'((c | 4) << (3 * j)));
        v1 = 32'h100 + 32'(j * 16 + c);
        wr(COUNT, v1);
        wr(FLAGS, 32'hFF);
        cap_in[j] = 1'b1;
        idle(5);
        if (c[0]) exp_cap[j] = v1;
        rd(CAP0 + AW'(j), v); chk("R7 rising capture", v, exp_cap[j]);
        rd(FLAGS, v); chk("R8 capture flag rise", v, c[0] ? 32'(1 << (4 + j)) : 0);
        v1 = v1 + 32'h1000;
        wr(COUNT, v1);
        wr(FLAGS, 32'hFF);
        cap_in[j] = 1'b0;
        idle(5);
        if (c[1]) exp_cap[j] = v1;
        rd(CAP0 + AW'(j), v); chk("R7 falling capture", v, exp_cap[j]);
        rd(FLAGS, v); chk("R8 capture flag fall", v, c[1] ? 32'(1 << (4 + j)) : 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule